// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block computes, one beat per clock, the column addresses that a synchronous DRAM visits during a burst. A controller or a memory model pulses `start_i` together with a starting column, a length code and an ordering bit. From the following cycle on, the block presents the column for each beat on `col_o`, with `valid_o` high for as long as the burst runs. `last_o` marks the final beat of a fixed-length burst.

Two orderings are supported. Sequential ordering counts upward inside the aligned block of the burst length. Interleaved ordering XORs the beat index into the low column bits. A page-length mode counts through every column position, wrapping at the end of the row, and runs until `term_i` stops it. Length and ordering pairs that are not allowed fall back to a single beat and raise `illegal_o`. When the single-write option is enabled, a write burst is cut to one beat.

Top module: `sdram_burst_colgen`

## Requirements
- R1: While `rst` is high, and on the cycle after it, `valid_o`, `last_o` and `illegal_o` are low and `col_o` is zero.
- R2: A `start_i` pulse makes `col_o` equal `start_col_i` and `valid_o` high on the next cycle. This also applies when a burst is already running, which is then abandoned.
- R3: With `ilv_i`=0, length codes 0, 1, 2 and 3 give bursts of 1, 2, 4 and 8 beats. Beat n carries the column whose low log2(length) bits are (start + n) mod length. All higher bits equal those of the start column.
- R4: With `ilv_i`=1, only codes 2 (4 beats) and 3 (8 beats) are legal. Beat n carries the start column XOR n.
- R5: Code 7 with `ilv_i`=0 selects a page-length burst. Each beat is the previous column plus one, modulo 1024. `last_o` stays low and the burst continues without limit.
- R6: `term_i` high during a valid beat, with no `start_i` in the same cycle, makes `valid_o` low on the next cycle.
- R7: `last_o` is high only on the final beat of a fixed-length burst. If no new start arrives in that cycle, `valid_o` is low on the next cycle.
- R8: Codes 4, 5 and 6, or `ilv_i`=1 with any code other than 2 or 3, run a one-beat burst. `illegal_o` is high from the first beat until the next start.
- R9: When `single_wr_i` and `wr_i` are both high at start, the burst has one beat whatever the code. For legal codes `illegal_o` stays low.
- R10: When `start_i` and `term_i` are high in the same cycle, the start wins and the new burst begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a burst at `start_col_i` |
| start_col_i | input | COL_W (10) | First column of the burst |
| len_code_i | input | 3 | Length code: 0..3 give 1/2/4/8 beats, 7 gives page length |
| ilv_i | input | 1 | 1 selects interleaved ordering |
| wr_i | input | 1 | The burst being started is a write |
| single_wr_i | input | 1 | Single-beat writes mode |
| term_i | input | 1 | Stop the running burst |
| col_o | output | COL_W (10) | Column of the current beat |
| valid_o | output | 1 | A burst beat is present |
| last_o | output | 1 | Final beat of a fixed-length burst |
| illegal_o | output | 1 | The latest start used a disallowed length/order pair |

## Verification
Several properties are checked on every cycle:
- The load of the start column, and start taking priority over terminate.
- The end of a burst one cycle after `last_o` or `term_i`.
- The fixed upper bits of fixed-length bursts, and the +1 step of page bursts.
- The one-beat fallback for illegal and single-write starts.

The exact per-beat order can only be shown by the bench scenarios, which compare each beat against columns computed independently. These include the wrap inside the aligned block for sequential ordering, the XOR pattern for interleaved ordering, the page wrap from 1023 to 0, and a restart in the middle of a burst.

// File: rtl/burst_pkg.sv
package burst_pkg;
  localparam int LEN_LOG_W = 2;
  localparam int CODE_W    = 3;
  localparam logic [CODE_W-1:0] CODE_PAGE = 3'd7;

  typedef struct packed {
    logic                 page;
    logic                 illegal;
    logic [LEN_LOG_W-1:0] len_log;
  } burst_cfg_t;
endpackage

// File: rtl/burst_len_decode.sv
module burst_len_decode
  import burst_pkg::*;
(
  input  logic [CODE_W-1:0] code_i,
  input  logic              ilv_i,
  input  logic              wr_i,
  input  logic              single_wr_i,
  output burst_cfg_t        cfg_o
);
  always_comb begin
    cfg_o = '0;
    case (code_i)
      3'd0, 3'd1, 3'd2, 3'd3: cfg_o.len_log = code_i[LEN_LOG_W-1:0];
      CODE_PAGE:              cfg_o.page    = 1'b1;
      default:                cfg_o.illegal = 1'b1;
    endcase
    if (ilv_i && !(code_i == 3'd2 || code_i == 3'd3))
      cfg_o.illegal = 1'b1;
    if (cfg_o.illegal || (wr_i && single_wr_i)) begin
      cfg_o.len_log = '0;
      cfg_o.page    = 1'b0;
    end
  end
endmodule

// File: rtl/burst_col_map.sv
module burst_col_map #(
  parameter int COL_W   = 10,
  parameter int LOG_W   = 2,
  parameter int MAX_LOG = 3
) (
  input  logic [COL_W-1:0]   base_i,
  input  logic [MAX_LOG-1:0] beat_i,
  input  logic [LOG_W-1:0]   len_log_i,
  input  logic               ilv_i,
  output logic [MAX_LOG-1:0] mask_o,
  output logic [COL_W-1:0]   col_o
);
  logic [MAX_LOG-1:0] low_base, low_seq, low_ilv, low_sel;

  for (genvar i = 0; i < MAX_LOG; i++) begin : g_mask
    assign mask_o[i] = (int'(len_log_i) > i);
  end

  assign low_base = base_i[MAX_LOG-1:0];
  assign low_seq  = ((low_base + beat_i) & mask_o) | (low_base & ~mask_o);
  assign low_ilv  = low_base ^ (beat_i & mask_o);
  assign low_sel  = ilv_i ? low_ilv : low_seq;
  assign col_o    = {base_i[COL_W-1:MAX_LOG], low_sel};
endmodule

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen
  import burst_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [COL_W-1:0]  start_col_i,
  input  logic [2:0]        len_code_i,
  input  logic              ilv_i,
  input  logic              wr_i,
  input  logic              single_wr_i,
  input  logic              term_i,
  output logic [COL_W-1:0]  col_o,
  output logic              valid_o,
  output logic              last_o,
  output logic              illegal_o
);
  localparam int MAX_LOG = (1 << LEN_LOG_W) - 1;

  burst_cfg_t         cfg;
  logic               valid_q, last_q, page_q, ilv_q, illegal_q;
  logic [LEN_LOG_W-1:0] len_log_q;
  logic [COL_W-1:0]   base_q, col_q, mapped_col;
  logic [MAX_LOG-1:0] beat_q, beat_nxt, mask;

  burst_len_decode dec_i (
    .code_i      (len_code_i),
    .ilv_i       (ilv_i),
    .wr_i        (wr_i),
    .single_wr_i (single_wr_i),
    .cfg_o       (cfg)
  );

  assign beat_nxt = beat_q + 1'b1;

  burst_col_map #(.COL_W(COL_W), .LOG_W(LEN_LOG_W), .MAX_LOG(MAX_LOG)) map_i (
    .base_i    (base_q),
    .beat_i    (beat_nxt),
    .len_log_i (len_log_q),
    .ilv_i     (ilv_q),
    .mask_o    (mask),
    .col_o     (mapped_col)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q   <= 1'b0;
      last_q    <= 1'b0;
      page_q    <= 1'b0;
      ilv_q     <= 1'b0;
      illegal_q <= 1'b0;
      len_log_q <= '0;
      base_q    <= '0;
      col_q     <= '0;
      beat_q    <= '0;
    end else if (start_i) begin
      valid_q   <= 1'b1;
      last_q    <= !cfg.page && (cfg.len_log == '0);
      page_q    <= cfg.page;
      ilv_q     <= ilv_i;
      illegal_q <= cfg.illegal;
      len_log_q <= cfg.len_log;
      base_q    <= start_col_i;
      col_q     <= start_col_i;
      beat_q    <= '0;
    end else if (valid_q) begin
      if (term_i || last_q) begin
        valid_q <= 1'b0;
        last_q  <= 1'b0;
      end else if (page_q) begin
        col_q <= col_q + 1'b1;
      end else begin
        col_q  <= mapped_col;
        beat_q <= beat_nxt;
        last_q <= (beat_nxt == mask);
      end
    end
  end

  assign col_o     = col_q;
  assign valid_o   = valid_q;
  assign last_o    = last_q;
  assign illegal_o = illegal_q;
endmodule

// File: rtl/sdram_burst_colgen_chk.sv
module sdram_burst_colgen_chk #(
  parameter int COL_W   = 10,
  parameter int MAX_LOG = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             start_i,
  input logic [COL_W-1:0] start_col_i,
  input logic [2:0]       len_code_i,
  input logic             ilv_i,
  input logic             wr_i,
  input logic             single_wr_i,
  input logic             term_i,
  input logic [COL_W-1:0] col_o,
  input logic             valid_o,
  input logic             last_o,
  input logic             illegal_o,
  input logic             page_q
);
  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (!valid_o && !last_o && !illegal_o && col_o == '0));

  p_start_loads_r2: assert property (@(posedge clk) disable iff (rst)
    start_i |=> (valid_o && col_o == $past(start_col_i)));

  p_upper_fixed_r3: assert property (@(posedge clk) disable iff (rst)
    (valid_o && !last_o && !start_i && !term_i && !page_q) |=>
      (col_o[COL_W-1:MAX_LOG] == $past(col_o[COL_W-1:MAX_LOG])));

  p_page_step_r5: assert property (@(posedge clk) disable iff (rst)
    (valid_o && page_q && !start_i && !term_i) |=>
      (valid_o && !last_o && col_o == $past(col_o) + COL_W'(1)));

  p_term_stops_r6: assert property (@(posedge clk) disable iff (rst)
    (valid_o && term_i && !start_i) |=> !valid_o);

  p_last_ends_r7: assert property (@(posedge clk) disable iff (rst)
    (last_o && !start_i) |=> !valid_o);

  p_last_in_burst_r7: assert property (@(posedge clk) disable iff (rst)
    last_o |-> valid_o);

  p_illegal_single_r8: assert property (@(posedge clk) disable iff (rst)
    (start_i && ilv_i && len_code_i != 3'd2 && len_code_i != 3'd3) |=>
      (illegal_o && last_o));

  p_write_single_r9: assert property (@(posedge clk) disable iff (rst)
    (start_i && wr_i && single_wr_i) |=> last_o);

  p_start_beats_term_r10: assert property (@(posedge clk) disable iff (rst)
    (start_i && term_i) |=> valid_o);
endmodule

bind sdram_burst_colgen sdram_burst_colgen_chk #(.COL_W(COL_W), .MAX_LOG(MAX_LOG)) chk_i (
  .clk(clk), .rst(rst), .start_i(start_i), .start_col_i(start_col_i),
  .len_code_i(len_code_i), .ilv_i(ilv_i), .wr_i(wr_i), .single_wr_i(single_wr_i),
  .term_i(term_i), .col_o(col_o), .valid_o(valid_o), .last_o(last_o),
  .illegal_o(illegal_o), .page_q(page_q)
);

// File: tb/sdram_burst_colgen_tb_top.sv
module sdram_burst_colgen_tb_top;
  localparam int COL_W = 10;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             start_i = 1'b0;
  logic [COL_W-1:0] start_col_i = '0;
  logic [2:0]       len_code_i = '0;
  logic             ilv_i = 1'b0, wr_i = 1'b0, single_wr_i = 1'b0, term_i = 1'b0;
  logic [COL_W-1:0] col_o;
  logic             valid_o, last_o, illegal_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  sdram_burst_colgen #(.COL_W(COL_W)) dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .start_col_i(start_col_i),
    .len_code_i(len_code_i), .ilv_i(ilv_i), .wr_i(wr_i), .single_wr_i(single_wr_i),
    .term_i(term_i), .col_o(col_o), .valid_o(valid_o), .last_o(last_o),
    .illegal_o(illegal_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_col(int s, int n, int len, bit ilv);
    int blk;
    if (ilv) return s ^ n;
    blk = s - (s % len);
    return blk + ((s % len) + n) % len;
  endfunction

  // called at a negedge; returns at the negedge where beat 0 is visible
  task automatic pulse_start(int col, int code, bit ilv, bit wr, bit sw, bit term);
    start_i = 1'b1; start_col_i = COL_W'(col); len_code_i = 3'(code);
    ilv_i = ilv; wr_i = wr; single_wr_i = sw; term_i = term;
    @(negedge clk);
    start_i = 1'b0; term_i = 1'b0; wr_i = 1'b0; single_wr_i = 1'b0;
  endtask

  task automatic run_fixed(string req, int col, int code, bit ilv, bit wr, bit sw,
                           int len, bit exp_ill);
    pulse_start(col, code, ilv, wr, sw, 1'b0);
    check(illegal_o == exp_ill, req, illegal_o, exp_ill);
    for (int n = 0; n < len; n++) begin
      check(valid_o && col_o == COL_W'(exp_col(col, n, len, ilv)), req,
            valid_o ? int'(col_o) : -1, exp_col(col, n, len, ilv));
      check(last_o == (n == len - 1), {req, " last"}, last_o, n == len - 1);
      @(negedge clk);
    end
    check(!valid_o && !last_o, {req, " end R7"}, valid_o, 0);
  endtask

  task automatic t_reset;
    check(!valid_o && !last_o && !illegal_o && col_o == '0, "R1", valid_o, 0);
  endtask

  task automatic t_sequential;
    run_fixed("R3 len1", 10'h155, 0, 0, 0, 0, 1, 0);
    run_fixed("R3 len2", 10'h0F3, 1, 0, 0, 0, 2, 0);
    run_fixed("R3 len4", 10'h005, 2, 0, 0, 0, 4, 0);
    run_fixed("R3 len8", 10'h1FD, 3, 0, 0, 0, 8, 0);
  endtask

  task automatic t_interleaved;
    run_fixed("R4 len4", 10'h005, 2, 1, 0, 0, 4, 0);
    run_fixed("R4 len8", 10'h1FD, 3, 1, 0, 0, 8, 0);
    run_fixed("R4 len8 b", 10'h3FA, 3, 1, 0, 0, 8, 0);
  endtask

  task automatic t_page;
    pulse_start(1022, 7, 0, 0, 0, 0);
    for (int n = 0; n < 1030; n++) begin
      check(valid_o && !last_o && col_o == COL_W'((1022 + n) % 1024), "R5",
            int'(col_o), (1022 + n) % 1024);
      if (n == 1029) term_i = 1'b1;
      @(negedge clk);
    end
    term_i = 1'b0;
    check(!valid_o, "R6 page term", valid_o, 0);
  endtask

  task automatic t_term_fixed;
    pulse_start(10'h040, 3, 0, 0, 0, 0);
    @(negedge clk);
    check(col_o == 10'h041, "R6 beat1", int'(col_o), 10'h041);
    term_i = 1'b1;
    @(negedge clk);
    term_i = 1'b0;
    check(!valid_o && !last_o, "R6 fixed term", valid_o, 0);
  endtask

  task automatic t_illegal;
    run_fixed("R8 ilv len2", 10'h2A1, 1, 1, 0, 0, 1, 1);
    run_fixed("R8 code5", 10'h0A2, 5, 0, 0, 0, 1, 1);
    run_fixed("R8 ilv page", 10'h033, 7, 1, 0, 0, 1, 1);
    run_fixed("R8 cleared", 10'h010, 1, 0, 0, 0, 2, 0);
  endtask

  task automatic t_single_write;
    run_fixed("R9 wr len8", 10'h123, 3, 0, 1, 1, 1, 0);
    run_fixed("R9 wr page", 10'h3FF, 7, 0, 1, 1, 1, 0);
    run_fixed("R9 read keeps len", 10'h123, 2, 0, 0, 1, 4, 0);
    run_fixed("R9 write no mode", 10'h123, 1, 0, 1, 0, 2, 0);
  endtask

  task automatic t_restart;
    pulse_start(10'h100, 3, 0, 0, 0, 0);
    @(negedge clk);
    @(negedge clk);
    check(col_o == 10'h102, "R2 pre-restart", int'(col_o), 10'h102);
    start_i = 1'b1; start_col_i = 10'h2A5; len_code_i = 3'd2; ilv_i = 1'b0;
    @(negedge clk);
    start_i = 1'b0;
    for (int n = 0; n < 4; n++) begin
      check(valid_o && col_o == COL_W'(exp_col(10'h2A5, n, 4, 0)), "R2 restart",
            int'(col_o), exp_col(10'h2A5, n, 4, 0));
      @(negedge clk);
    end
    check(!valid_o, "R2 restart end", valid_o, 0);
  endtask

  task automatic t_start_over_term;
    pulse_start(10'h300, 3, 0, 0, 0, 0);
    pulse_start(10'h017, 3, 1, 0, 0, 1);
    check(valid_o && col_o == 10'h017, "R10", int'(col_o), 10'h017);
    @(negedge clk);
    check(valid_o && col_o == 10'h016, "R10 beat1", int'(col_o), 10'h016);
    term_i = 1'b1;
    @(negedge clk);
    term_i = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_sequential();
    t_interleaved();
    t_page();
    t_term_fixed();
    t_illegal();
    t_single_write();
    t_restart();
    t_start_over_term();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule